// File: doc/BRIEF.md
# NAND ECC Register Front-End

This block is the register face of a Reed-Solomon error-correction engine used when pages are moved to and from NAND flash. Software talks to it over a plain 32-bit read/write port with byte enables. It programs a control word, loads or collects nine parity bytes, and polls or takes an interrupt on a status word. After a decode run it reads back per-error records. The arithmetic itself lives in a separate engine. This block only sequences that engine through a small handshake: a start pulse, a mode level, a "parity loaded, begin checking" pulse, an abort pulse and a done input that carries results.

A run opens when software writes the control word with both the enable and the reset bits set. The reset bit drops by itself on the next clock, and on that clock the status word and the error records are wiped and the engine receives its start pulse. An encode run ends when the engine reports done, and the computed parity is then held for reading. A decode run needs the parity bytes loaded first and the parity-loaded bit set, and it ends with flags, an error count and the records. One parity value is special. The parity the engine computes for a block of all-ones bytes is shown to software as nine 0xFF bytes, so that blank pages stay blank after programming.

Top module: `ecc_reg_front`

## Requirements
- R1: After reset, every register reads as zero, and irq, eng_start, eng_check, eng_abort and eng_data_we are low.
- R2: The control word is at 0x00: enable at bit 0, run-reset at bit 1, Reed-Solomon mode at bit 2, encode (1) or decode (0) at bit 3, parity-loaded at bit 4. A write that sets both enable and run-reset gives a one-cycle eng_start in the second cycle after the write. The run-reset bit then reads back as zero, and eng_encode and eng_rs follow bits 3 and 2.
- R3: Parity byte k (0 to 8) lives at byte address 0x08+k, in lane k mod 4 of the word at 0x08, 0x0C or 0x10. Only the bytes whose enables are set are written. All nine bytes read back and appear on eng_par_out, with byte k at bits 8k+7:8k.
- R4: During a decode run, a control write that keeps enable set and sets parity-loaded gives a one-cycle eng_check in the cycle after the write. During an encode run, the same write gives no eng_check.
- R5: When the engine reports done in an encode run, status bit 2 is set and eng_par_in is stored as the parity bytes.
- R6: Computed parity equal to bytes cd 9d 90 58 f4 8b ff b7 6f (byte 0 first) reads back as nine 0xFF bytes, while eng_par_out still carries the raw value. The same bytes written over the bus read back unchanged.
- R7: When the engine reports done in a decode run, status bit 3 is set. Bit 0 is set when the count is nonzero or the run is uncorrectable, and bit 1 is set when it is uncorrectable. Bits 31:29 take the error count, clamped to NUM_REC. Record n at 0x1C+4n holds the 1-based symbol index in bits 24:16 and the 9-bit mask in bits 8:0, and records at or above the count read zero.
- R8: A write to status (0x14) keeps each flag or count bit only where the written value has a one, in the enabled bytes, so writing zero clears everything.
- R9: The interrupt enable word is at 0x18, bits 4:0. irq is registered and rises one cycle after any status bit 4:0 and its enable bit are both set.
- R10: A control write that clears enable while a run is active gives a one-cycle eng_abort and sets no finished flag. A done that arrives after the abort is ignored, including its parity.
- R11: The run-reset bit clears the status word and all error records.
- R12: A write to the data word at 0x04 is passed on to eng_data and eng_data_be with a one-cycle eng_data_we in the cycle after the write. The data word reads as zero.
- R13: A pulse on eng_pad_done sets status bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe; data is returned on the next cycle |
| bus_addr | input | ADDR_W | Byte address |
| bus_be | input | 4 | Byte enables for writes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| eng_start | output | 1 | One-cycle pulse that starts a run |
| eng_check | output | 1 | One-cycle pulse: parity loaded, begin decode check |
| eng_abort | output | 1 | One-cycle pulse: run abandoned |
| eng_encode | output | 1 | Mode level, 1 for encode |
| eng_rs | output | 1 | Reed-Solomon mode level |
| eng_data_we | output | 1 | Data word forwarded to the engine |
| eng_data | output | 32 | Forwarded data word |
| eng_data_be | output | 4 | Forwarded byte enables |
| eng_par_out | output | 72 | Stored parity bytes, raw |
| eng_done | input | 1 | Engine has finished the run |
| eng_pad_done | input | 1 | Engine has finished padding |
| eng_par_in | input | 72 | Computed parity, valid with eng_done |
| eng_uncor | input | 1 | Decode found uncorrectable errors |
| eng_err_cnt | input | 3 | Number of corrected errors |
| eng_err_idx | input | NUM_REC*9 | 1-based symbol index per record |
| eng_err_mask | input | NUM_REC*9 | Error mask per record |
| irq | output | 1 | Interrupt request |

## Verification
The bench aims at the blank-page parity substitution from both sides. A design that compared the wrong byte order, or that also rewrote parity loaded by software, would return the wrong words. It checks that records at or above the reported count read zero and that a count of seven is clamped, which catches a design that copies stale engine lanes or lets the count exceed the record store. It aborts an encode run and then delivers a late done, which exposes a design that still sets the finished flag or stores the parity. It also issues a parity-loaded write during an encode run, where a design that ignored the mode would fire the decode check.

// File: rtl/ecc_fe_pkg.sv
package ecc_fe_pkg;

  localparam int unsigned PAR_BYTES = 9;
  localparam int unsigned PAR_W     = 8 * PAR_BYTES;
  localparam int unsigned SYM_W     = 9;

  // word indices (byte address >> 2)
  localparam int WA_CTRL = 0;
  localparam int WA_DATA = 1;
  localparam int WA_PAR  = 2;
  localparam int WA_STAT = 5;
  localparam int WA_IEN  = 6;
  localparam int WA_REC  = 7;

  // control bits
  localparam int B_EN   = 0;
  localparam int B_RST  = 1;
  localparam int B_RS   = 2;
  localparam int B_ENC  = 3;
  localparam int B_PRDY = 4;

  // status bits
  localparam int S_ERR = 0;
  localparam int S_UNC = 1;
  localparam int S_ENC = 2;
  localparam int S_DEC = 3;
  localparam int S_PAD = 4;

  // parity of an all-ones block, byte 0 in the low bits
  localparam logic [PAR_W-1:0] BLANK_PAR = 72'h6f_b7_ff_8b_f4_58_90_9d_cd;

  typedef struct packed {
    logic [SYM_W-1:0] idx;
    logic [SYM_W-1:0] mask;
  } err_rec_t;

endpackage

// File: rtl/ecc_fe_parity.sv
module ecc_fe_parity
  import ecc_fe_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic [PAR_BYTES-1:0] byte_we,
  input  logic [PAR_W-1:0]     byte_wd,
  input  logic                 cap,
  input  logic [PAR_W-1:0]     cap_data,
  output logic [PAR_W-1:0]     par_raw,
  output logic [PAR_W-1:0]     par_view
);

  logic from_eng;

  for (genvar k = 0; k < PAR_BYTES; k++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst)             par_raw[8*k +: 8] <= '0;
      else if (cap)        par_raw[8*k +: 8] <= cap_data[8*k +: 8];
      else if (byte_we[k]) par_raw[8*k +: 8] <= byte_wd[8*k +: 8];
    end
  end

  // substitution applies only to parity the engine produced
  always_ff @(posedge clk) begin
    if (rst)           from_eng <= 1'b0;
    else if (cap)      from_eng <= 1'b1;
    else if (|byte_we) from_eng <= 1'b0;
  end

  assign par_view = (from_eng && par_raw == BLANK_PAR) ? {PAR_W{1'b1}} : par_raw;

endmodule

// File: rtl/ecc_fe_seq.sv
module ecc_fe_seq
  import ecc_fe_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       ctrl_we,
  input  logic [4:0] ctrl_wd,
  input  logic       eng_done,
  output logic [4:0] ctrl_q,
  output logic       busy,
  output logic       eng_start,
  output logic       eng_check,
  output logic       eng_abort,
  output logic       done_acc
);

  logic kill, wr_abort, wr_check;

  assign kill     = ctrl_we && !ctrl_wd[B_EN];
  assign wr_abort = kill && busy;
  assign wr_check = ctrl_we && busy && !ctrl_q[B_RST] && !ctrl_q[B_ENC] &&
                    !ctrl_wd[B_ENC] && ctrl_wd[B_EN] && ctrl_wd[B_PRDY] &&
                    !ctrl_q[B_PRDY];
  assign done_acc = eng_done && busy && !ctrl_q[B_RST] && !wr_abort;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q    <= '0;
      busy      <= 1'b0;
      eng_start <= 1'b0;
      eng_check <= 1'b0;
      eng_abort <= 1'b0;
    end else begin
      eng_start <= 1'b0;
      eng_check <= wr_check;
      eng_abort <= wr_abort;
      if (ctrl_q[B_RST]) begin
        ctrl_q[B_RST]  <= 1'b0;
        ctrl_q[B_PRDY] <= 1'b0;
        busy           <= ctrl_q[B_EN];
        eng_start      <= ctrl_q[B_EN] && !kill;
      end else if (done_acc) begin
        busy <= 1'b0;
      end
      if (ctrl_we) ctrl_q <= ctrl_wd;
      if (kill)    busy   <= 1'b0;
    end
  end

endmodule

// File: rtl/ecc_fe_status.sv
module ecc_fe_status
  import ecc_fe_pkg::*;
#(
  parameter int NUM_REC = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       clr,
  input  logic                       stat_we,
  input  logic [1:0]                 stat_be,
  input  logic [4:0]                 wd_flags,
  input  logic [2:0]                 wd_cnt,
  input  logic                       ien_we,
  input  logic [4:0]                 ien_wd,
  input  logic                       enc_done,
  input  logic                       dec_done,
  input  logic                       pad_done,
  input  logic                       eng_uncor,
  input  logic [2:0]                 eng_cnt,
  input  logic [NUM_REC*SYM_W-1:0]   eng_idx,
  input  logic [NUM_REC*SYM_W-1:0]   eng_mask,
  output logic [4:0]                 flags,
  output logic [2:0]                 cnt,
  output logic [4:0]                 ien,
  output logic [NUM_REC*2*SYM_W-1:0] rec_flat,
  output logic                       irq
);

  localparam logic [2:0] CNT_MAX = 3'(NUM_REC);

  logic [2:0] cnt_cl;
  logic       err_any;

  assign cnt_cl  = (eng_cnt > CNT_MAX) ? CNT_MAX : eng_cnt;
  assign err_any = eng_uncor || (eng_cnt != 3'd0);

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      flags <= '0;
      cnt   <= '0;
    end else begin
      if (stat_we) begin
        if (stat_be[0]) flags <= flags & wd_flags;
        if (stat_be[1]) cnt   <= cnt & wd_cnt;
      end
      if (enc_done) flags[S_ENC] <= 1'b1;
      if (pad_done) flags[S_PAD] <= 1'b1;
      if (dec_done) begin
        flags[S_DEC] <= 1'b1;
        flags[S_ERR] <= err_any;
        flags[S_UNC] <= eng_uncor;
        cnt          <= cnt_cl;
      end
    end
  end

  for (genvar i = 0; i < NUM_REC; i++) begin : g_rec
    err_rec_t rec_q;
    always_ff @(posedge clk) begin
      if (rst || clr) begin
        rec_q <= '0;
      end else if (dec_done) begin
        if (3'(i) < cnt_cl) rec_q <= '{idx: eng_idx[SYM_W*i +: SYM_W], mask: eng_mask[SYM_W*i +: SYM_W]};
        else                rec_q <= '0;
      end
    end
    assign rec_flat[2*SYM_W*i +: 2*SYM_W] = rec_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien <= '0;
      irq <= 1'b0;
    end else begin
      if (ien_we) ien <= ien_wd;
      irq <= |(flags & ien);
    end
  end

endmodule

// File: rtl/ecc_reg_front.sv
module ecc_reg_front
  import ecc_fe_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int NUM_REC = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     bus_wr,
  input  logic                     bus_rd,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [3:0]               bus_be,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     eng_start,
  output logic                     eng_check,
  output logic                     eng_abort,
  output logic                     eng_encode,
  output logic                     eng_rs,
  output logic                     eng_data_we,
  output logic [31:0]              eng_data,
  output logic [3:0]               eng_data_be,
  output logic [71:0]              eng_par_out,
  input  logic                     eng_done,
  input  logic                     eng_pad_done,
  input  logic [71:0]              eng_par_in,
  input  logic                     eng_uncor,
  input  logic [2:0]               eng_err_cnt,
  input  logic [NUM_REC*9-1:0]     eng_err_idx,
  input  logic [NUM_REC*9-1:0]     eng_err_mask,
  output logic                     irq
);

  localparam int WA_W  = ADDR_W - 2;
  localparam int REC_W = 2 * SYM_W;

  logic [WA_W-1:0] wa;
  wire             unused_lo = ^bus_addr[1:0];

  assign wa = bus_addr[ADDR_W-1:2];

  logic ctrl_we, stat_we, ien_we, data_we;
  assign ctrl_we = bus_wr && int'(wa) == WA_CTRL && bus_be[0];
  assign stat_we = bus_wr && int'(wa) == WA_STAT;
  assign ien_we  = bus_wr && int'(wa) == WA_IEN && bus_be[0];
  assign data_we = bus_wr && int'(wa) == WA_DATA;

  // parity byte lanes
  logic [PAR_BYTES-1:0] byte_we;
  logic [PAR_W-1:0]     byte_wd;
  for (genvar k = 0; k < PAR_BYTES; k++) begin : g_lane
    assign byte_we[k]        = bus_wr && int'(wa) == WA_PAR + k / 4 && bus_be[k % 4];
    assign byte_wd[8*k +: 8] = bus_wdata[8*(k % 4) +: 8];
  end

  logic [4:0] ctrl_q;
  logic       busy, done_acc;

  ecc_fe_seq u_seq (
    .clk       (clk),
    .rst       (rst),
    .ctrl_we   (ctrl_we),
    .ctrl_wd   (bus_wdata[4:0]),
    .eng_done  (eng_done),
    .ctrl_q    (ctrl_q),
    .busy      (busy),
    .eng_start (eng_start),
    .eng_check (eng_check),
    .eng_abort (eng_abort),
    .done_acc  (done_acc)
  );

  assign eng_encode = ctrl_q[B_ENC];
  assign eng_rs     = ctrl_q[B_RS];

  logic enc_done, dec_done;
  assign enc_done = done_acc && ctrl_q[B_ENC];
  assign dec_done = done_acc && !ctrl_q[B_ENC];

  logic [PAR_W-1:0] par_view;

  ecc_fe_parity u_par (
    .clk      (clk),
    .rst      (rst),
    .byte_we  (byte_we),
    .byte_wd  (byte_wd),
    .cap      (enc_done),
    .cap_data (eng_par_in),
    .par_raw  (eng_par_out),
    .par_view (par_view)
  );

  logic [4:0]               flags, ien_q;
  logic [2:0]               cnt;
  logic [NUM_REC*REC_W-1:0] rec_flat;

  ecc_fe_status #(.NUM_REC(NUM_REC)) u_stat (
    .clk       (clk),
    .rst       (rst),
    .clr       (ctrl_q[B_RST]),
    .stat_we   (stat_we),
    .stat_be   ({bus_be[3], bus_be[0]}),
    .wd_flags  (bus_wdata[4:0]),
    .wd_cnt    (bus_wdata[31:29]),
    .ien_we    (ien_we),
    .ien_wd    (bus_wdata[4:0]),
    .enc_done  (enc_done),
    .dec_done  (dec_done),
    .pad_done  (eng_pad_done),
    .eng_uncor (eng_uncor),
    .eng_cnt   (eng_err_cnt),
    .eng_idx   (eng_err_idx),
    .eng_mask  (eng_err_mask),
    .flags     (flags),
    .cnt       (cnt),
    .ien       (ien_q),
    .rec_flat  (rec_flat),
    .irq       (irq)
  );

  logic [31:0] stat_word;
  assign stat_word = {cnt, 24'd0, flags};

  logic [31:0] rd_word;
  always_comb begin
    rd_word = '0;
    if (int'(wa) == WA_CTRL) rd_word[4:0] = ctrl_q;
    if (int'(wa) == WA_STAT) rd_word = stat_word;
    if (int'(wa) == WA_IEN)  rd_word[4:0] = ien_q;
    for (int k = 0; k < PAR_BYTES; k++)
      if (int'(wa) == WA_PAR + k / 4) rd_word[8*(k % 4) +: 8] = par_view[8*k +: 8];
    for (int n = 0; n < NUM_REC; n++)
      if (int'(wa) == WA_REC + n)
        rd_word = {7'd0, rec_flat[REC_W*n + SYM_W +: SYM_W], 7'd0, rec_flat[REC_W*n +: SYM_W]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata   <= '0;
      eng_data_we <= 1'b0;
      eng_data    <= '0;
      eng_data_be <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      eng_data_we <= data_we;
      if (data_we) begin
        eng_data    <= bus_wdata;
        eng_data_be <= bus_be;
      end
    end
  end

endmodule

// File: rtl/ecc_reg_front_chk.sv
module ecc_reg_front_chk #(
  parameter int NUM_REC = 4
) (
  input logic       clk,
  input logic       rst,
  input logic       ctrl_rst,
  input logic       ctrl_we,
  input logic       busy,
  input logic       eng_start,
  input logic       eng_check,
  input logic       eng_abort,
  input logic       eng_encode,
  input logic [1:0] done_flags,
  input logic [2:0] cnt,
  input logic [4:0] ien,
  input logic       irq
);

  AST_RST_SELF_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (ctrl_rst && !ctrl_we) |=> !ctrl_rst);                                   // R2

  AST_START_AFTER_RST: assert property (@(posedge clk) disable iff (rst)
    eng_start |-> (busy && $past(ctrl_rst)));                                // R2

  AST_CHECK_IN_DECODE: assert property (@(posedge clk) disable iff (rst)
    eng_check |-> (busy && !eng_encode));                                    // R4

  AST_FINISH_NEEDS_RUN: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flags[0]) |-> $past(busy));                                   // R5

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= 3'(NUM_REC));                                                     // R7

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (rst)
    (ien == 5'd0) |=> !irq);                                                 // R9

  AST_ABORT_NO_FINISH: assert property (@(posedge clk) disable iff (rst)
    eng_abort |-> (!busy && $stable(done_flags)));                           // R10

endmodule

bind ecc_reg_front ecc_reg_front_chk #(.NUM_REC(NUM_REC)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .ctrl_rst   (ctrl_q[1]),
  .ctrl_we    (ctrl_we),
  .busy       (busy),
  .eng_start  (eng_start),
  .eng_check  (eng_check),
  .eng_abort  (eng_abort),
  .eng_encode (eng_encode),
  .done_flags (flags[3:2]),
  .cnt        (cnt),
  .ien        (ien_q),
  .irq        (irq)
);

// File: tb/ecc_reg_front_test.sv
module ecc_reg_front_test;

  localparam int CLK_PERIOD = 10;
  localparam int NREC       = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]        bus_addr = '0;
  logic [3:0]        bus_be = '0;
  logic [31:0]       bus_wdata = '0;
  logic [31:0]       bus_rdata;
  logic              eng_start, eng_check, eng_abort, eng_encode, eng_rs;
  logic              eng_data_we;
  logic [31:0]       eng_data;
  logic [3:0]        eng_data_be;
  logic [71:0]       eng_par_out;
  logic              eng_done = 1'b0, eng_pad_done = 1'b0, eng_uncor = 1'b0;
  logic [71:0]       eng_par_in = '0;
  logic [2:0]        eng_err_cnt = '0;
  logic [NREC*9-1:0] eng_err_idx = '0, eng_err_mask = '0;
  logic              irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  ecc_reg_front #(.ADDR_W(8), .NUM_REC(NREC)) uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_be(bus_be), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .eng_start(eng_start), .eng_check(eng_check), .eng_abort(eng_abort),
    .eng_encode(eng_encode), .eng_rs(eng_rs), .eng_data_we(eng_data_we),
    .eng_data(eng_data), .eng_data_be(eng_data_be), .eng_par_out(eng_par_out),
    .eng_done(eng_done), .eng_pad_done(eng_pad_done), .eng_par_in(eng_par_in),
    .eng_uncor(eng_uncor), .eng_err_cnt(eng_err_cnt), .eng_err_idx(eng_err_idx),
    .eng_err_mask(eng_err_mask), .irq(irq)
  );

  int checks = 0;
  int errors = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_seen = 1'b0;

  task automatic chk(input logic [71:0] act, input logic [71:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: compare each returned read against the scoreboard
  always @(posedge clk) rd_seen <= bus_rd;
  always @(negedge clk) begin
    if (rd_seen) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: actual %h expected none", bus_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        chk({40'd0, bus_rdata}, {40'd0, e}, t);
      end
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
    @(negedge clk);
    bus_wr = 1'b0; bus_be = '0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] e, input string tag);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(tag);
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic finish_run(input logic [71:0] par, input logic unc, input logic [2:0] cnt);
    @(negedge clk);
    eng_done = 1'b1; eng_par_in = par; eng_uncor = unc; eng_err_cnt = cnt;
    @(negedge clk);
    eng_done = 1'b0; eng_uncor = 1'b0; eng_err_cnt = '0;
  endtask

  task automatic summary;
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual hung expected finish");
    summary();
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    @(negedge clk);
    chk({67'd0, irq, eng_start, eng_check, eng_abort, eng_data_we}, 72'd0, "R1 outputs");
    rd(8'h00, 32'h0, "R1 ctrl");
    rd(8'h14, 32'h0, "R1 status");
    rd(8'h18, 32'h0, "R1 ien");
    rd(8'h08, 32'h0, "R1 parity");
    rd(8'h1C, 32'h0, "R1 record");

    // R12 data forwarding
    wr(8'h04, 32'hDEADBEEF, 4'hF);
    chk({35'd0, eng_data_we, eng_data_be, eng_data}, {35'd1, 4'hF, 32'hDEADBEEF}, "R12 forward");
    @(negedge clk);
    chk({71'd0, eng_data_we}, 72'd0, "R12 pulse");
    rd(8'h04, 32'h0, "R12 read zero");

    // R3 byte-addressed parity
    wr(8'h08, 32'h44332211, 4'hF);
    wr(8'h0C, 32'h00AA0000, 4'b0100);
    wr(8'h10, 32'h000000EE, 4'b0001);
    rd(8'h08, 32'h44332211, "R3 word0");
    rd(8'h0C, 32'h00AA0000, "R3 word1");
    rd(8'h10, 32'h000000EE, "R3 word2");
    chk(eng_par_out, 72'hEE00AA000044332211, "R3 par_out");

    // R2 / R5 encode run
    wr(8'h00, 32'h0F, 4'h1);
    @(negedge clk);
    chk({69'd0, eng_start, eng_encode, eng_rs}, 72'h7, "R2 start");
    @(negedge clk);
    chk({71'd0, eng_start}, 72'd0, "R2 start one cycle");
    rd(8'h00, 32'h0D, "R2 reset bit self clear");
    wr(8'h00, 32'h1D, 4'h1);
    chk({71'd0, eng_check}, 72'd0, "R4 no check in encode");
    finish_run(72'h123456789ABCDEF012, 1'b0, 3'd0);
    rd(8'h14, 32'h4, "R5 encode flag");
    rd(8'h08, 32'hBCDEF012, "R5 parity0");
    rd(8'h0C, 32'h3456789A, "R5 parity1");
    rd(8'h10, 32'h00000012, "R5 parity2");

    // R6 blank substitution
    wr(8'h00, 32'h0F, 4'h1);
    repeat (2) @(negedge clk);
    finish_run(72'h6fb7ff8bf458909dcd, 1'b0, 3'd0);
    rd(8'h08, 32'hFFFFFFFF, "R6 blank0");
    rd(8'h0C, 32'hFFFFFFFF, "R6 blank1");
    rd(8'h10, 32'h000000FF, "R6 blank2");
    chk(eng_par_out, 72'h6fb7ff8bf458909dcd, "R6 raw par_out");
    wr(8'h08, 32'h58909dcd, 4'hF);
    rd(8'h08, 32'h58909dcd, "R6 sw write raw0");
    rd(8'h0C, 32'hb7ff8bf4, "R6 sw write raw1");

    // R10 abort
    wr(8'h00, 32'h0F, 4'h1);
    repeat (2) @(negedge clk);
    wr(8'h00, 32'h0C, 4'h1);
    chk({71'd0, eng_abort}, 72'd1, "R10 abort pulse");
    @(negedge clk);
    chk({71'd0, eng_abort}, 72'd0, "R10 abort one cycle");
    finish_run(72'h1, 1'b0, 3'd0);
    rd(8'h14, 32'h0, "R10 no finish flag");
    rd(8'h10, 32'h0000006F, "R10 parity kept");

    // R4 / R7 decode run
    eng_err_idx  = {9'd4, 9'd3, 9'h1FF, 9'd5};
    eng_err_mask = {9'd4, 9'd3, 9'h0AA, 9'h101};
    wr(8'h00, 32'h07, 4'h1);
    @(negedge clk);
    chk({70'd0, eng_start, eng_encode}, 72'h2, "R2 decode start");
    @(negedge clk);
    wr(8'h00, 32'h15, 4'h1);
    chk({71'd0, eng_check}, 72'd1, "R4 check pulse");
    @(negedge clk);
    chk({71'd0, eng_check}, 72'd0, "R4 check one cycle");
    finish_run(72'h0, 1'b0, 3'd2);
    rd(8'h14, 32'h40000009, "R7 status");
    rd(8'h1C, 32'h00050101, "R7 rec0");
    rd(8'h20, 32'h01FF00AA, "R7 rec1");
    rd(8'h24, 32'h0, "R7 rec2 beyond count");
    rd(8'h28, 32'h0, "R7 rec3 beyond count");
    chk({71'd0, irq}, 72'd0, "R9 irq masked");

    // R9 interrupt
    wr(8'h18, 32'h08, 4'h1);
    @(negedge clk);
    chk({71'd0, irq}, 72'd1, "R9 irq raised");
    rd(8'h18, 32'h08, "R9 ien readback");

    // R8 status clearing
    wr(8'h14, 32'hFFFFFFF7, 4'hF);
    @(negedge clk);
    chk({71'd0, irq}, 72'd0, "R9 irq dropped");
    rd(8'h14, 32'h40000001, "R8 partial clear");
    wr(8'h14, 32'h0, 4'hF);
    rd(8'h14, 32'h0, "R8 clear all");

    // R7 clamp
    wr(8'h00, 32'h07, 4'h1);
    repeat (2) @(negedge clk);
    wr(8'h00, 32'h15, 4'h1);
    finish_run(72'h0, 1'b1, 3'd7);
    rd(8'h14, 32'h8000000B, "R7 clamp status");
    rd(8'h24, 32'h00030003, "R7 rec2");
    rd(8'h28, 32'h00040004, "R7 rec3");

    // R11 run-reset clears
    wr(8'h00, 32'h03, 4'h1);
    repeat (2) @(negedge clk);
    rd(8'h14, 32'h0, "R11 status cleared");
    rd(8'h1C, 32'h0, "R11 records cleared");
    rd(8'h00, 32'h01, "R11 ctrl");

    // R13 padding
    @(negedge clk); eng_pad_done = 1'b1;
    @(negedge clk); eng_pad_done = 1'b0;
    rd(8'h14, 32'h10, "R13 pad flag");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    summary();
    $finish;
  end

endmodule